// File: doc/BRIEF.md
# Signed Multiply/Divide Unit with Condition Codes

This unit performs the two long arithmetic operations of a 16-bit minicomputer-style processor: a signed 16x16 multiply that yields a 32-bit product, and a signed 32/16 divide that yields a 16-bit quotient and a 16-bit remainder. The processor core hands over an operation select, the contents of an even/odd register pair (high word and low word), a source operand and a start strobe. After a fixed number of cycles the unit returns the two result words, a register write-enable and the four condition codes N, Z, V and C, all marked by a single-cycle done pulse.

The multiply completes in one computing cycle. The divide first screens out a zero divisor and the one special dividend/divisor pairing. It then runs a restoring division on magnitudes, one quotient bit per clock, and applies the signs in a final fix-up step. The fix-up step also detects a quotient that does not fit in 16 bits. Whenever a divide does not write, the result words show the unchanged register pair.

The control is a state machine with six states. IDLE waits for start. MUL forms the product. DIV_CHECK screens the operands and loads the iterative core. DIV_RUN steps the core. DIV_FIX applies signs and checks the range. DONE presents the results for one cycle. The transitions are: IDLE->MUL on start with multiply selected, IDLE->DIV_CHECK on start with divide selected, MUL->DONE, DIV_CHECK->DONE for a zero divisor or the special case, DIV_CHECK->DIV_RUN otherwise, DIV_RUN->DIV_RUN until the last quotient bit, DIV_RUN->DIV_FIX after it, DIV_FIX->DONE, and DONE->IDLE.

Top module: `muldiv_unit`

## Requirements
- R1: With `op`=0 (multiply), the unit forms the signed product of `pair_hi` and `src` (`pair_lo` is ignored). It puts product bits 31..16 on `res_hi` and bits 15..0 on `res_lo`, and asserts `wr_en` with done.
- R2: After a multiply, N equals product bit 31, Z is 1 only when the whole 32-bit product is zero, and V is 0.
- R3: After a multiply, C is 1 exactly when the product lies outside -32768..32767.
- R4: With `op`=1 (divide), the dividend is the signed 32-bit value {`pair_hi`,`pair_lo`} and the divisor is the signed `src`. On success the quotient, truncated toward zero, goes to `res_hi`, and the remainder, which carries the dividend's sign, goes to `res_lo`. `wr_en` is 1.
- R5: After a successful divide, V=0, C=0, N equals quotient bit 15, and Z=1 only when the quotient is zero.
- R6: When the true quotient is outside -32768..32767, `wr_en` stays 0, `res_hi`/`res_lo` show the unchanged pair, V=1 and N=Z=C=0.
- R7: A zero divisor gives `wr_en`=0, the unchanged pair on the result words, and N=0, Z=1, V=1, C=1. This takes precedence over every other divide case.
- R8: Dividend 0x80000000 with divisor 1 gives `wr_en`=0, the unchanged pair on the result words, and N=1, Z=1, V=1, C=0.
- R9: Counting the edge that samples start as edge 1, done is high after edge 2 for a multiply, a zero divisor or the special case, and after edge 35 for every other divide.
- R10: `busy` rises on the edge that accepts start and falls on the edge that ends done. done is high for exactly one cycle, and start has no effect while busy.
- R11: `wr_en` and all four flags are 0 in every cycle in which done is 0.
- R12: A synchronous reset returns the unit to IDLE: `busy`, `done`, `wr_en` and the flags are 0 after the reset edge, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| op | input | 1 | 0 = multiply, 1 = divide |
| pair_hi | input | 16 | Even register: multiplicand or dividend high word |
| pair_lo | input | 16 | Odd register: dividend low word |
| src | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write the result words back to the register pair |
| res_hi | output | 16 | Product high word or quotient |
| res_lo | output | 16 | Product low word or remainder |
| flag_n | output | 1 | Negative condition code |
| flag_z | output | 1 | Zero condition code |
| flag_v | output | 1 | Overflow condition code |
| flag_c | output | 1 | Carry condition code |

## Verification
Each result is due at a known edge. The product and the early divide outcomes (zero divisor, special case) are due after edge 2, counted from the edge that takes start. A full divide is due after edge 35: one screening edge, 32 iteration edges, one fix-up edge and one edge into DONE. The bench drives inputs on falling edges, counts rising edges from the one that accepts start, and samples at the falling edge that follows. It compares the edge count at which done first appears with the expected latency. It checks all outputs in that same half-cycle, and one cycle later checks that done, `wr_en` and the flags are back to zero.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_MUL       = 3'd1,
        S_DIV_CHECK = 3'd2,
        S_DIV_RUN   = 3'd3,
        S_DIV_FIX   = 3'd4,
        S_DONE      = 3'd5
    } md_state_t;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } md_cc_t;

    localparam md_cc_t CC_CLEAR    = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
    localparam md_cc_t CC_DIV_ZERO = '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
    localparam md_cc_t CC_DIV_ODD  = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};

endpackage

// File: rtl/muldiv_mul_path.sv
module muldiv_mul_path
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output md_cc_t       cc
);
    localparam int DW = 2 * W;

    logic signed [DW-1:0] product;
    logic [W:0]           upper_bits;
    logic                 fits_word;

    always_comb begin
        product    = $signed(mcand) * $signed(mplier);
        prod_hi    = product[DW-1:W];
        prod_lo    = product[W-1:0];
        // The product fits a signed word when bits DW-1..W-1 all agree.
        upper_bits = product[DW-1:W-1];
        fits_word  = (&upper_bits) | ~(|upper_bits);
        cc.n       = product[DW-1];
        cc.z       = (product == '0);
        cc.v       = 1'b0;
        cc.c       = ~fits_word;
    end

endmodule

// File: rtl/muldiv_div_iter.sv
module muldiv_div_iter #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]  divisor,
    output logic [2*W-1:0] q_mag,
    output logic [W-1:0]  r_mag,
    output logic          last
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    logic [DW-1:0] shift_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;

    logic [DW-1:0] dvd_abs;
    logic [W-1:0]  dsr_abs;
    logic [W:0]    rem_sh;
    logic [W:0]    diff;
    logic          take;

    always_comb begin
        dvd_abs = dividend[DW-1] ? (~dividend + 1'b1) : dividend;
        dsr_abs = divisor[W-1] ? (~divisor + 1'b1) : divisor;
        rem_sh  = {rem_q, shift_q[DW-1]};
        diff    = rem_sh - {1'b0, dsr_q};
        // rem_q < dsr_q keeps rem_sh below 2*dsr_q, so the top bit of
        // the difference is set exactly when the subtraction borrows.
        take    = ~diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            rem_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shift_q <= dvd_abs;
            rem_q   <= '0;
            dsr_q   <= dsr_abs;
            cnt_q   <= CW'(DW - 1);
        end else if (step) begin
            shift_q <= {shift_q[DW-2:0], take};
            rem_q   <= take ? diff[W-1:0] : rem_sh[W-1:0];
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign q_mag = shift_q;
    assign r_mag = rem_q;
    assign last  = (cnt_q == '0);

endmodule

// File: rtl/muldiv_div_fix.sv
module muldiv_div_fix
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] q_mag,
    input  logic [W-1:0]   r_mag,
    input  logic           dvd_neg,
    input  logic           dsr_neg,
    output logic [W-1:0]   quot,
    output logic [W-1:0]   rem,
    output logic           ovf,
    output md_cc_t         cc
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] LIM_POS = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [DW-1:0] LIM_NEG = LIM_POS + 1'b1;

    logic q_neg;

    always_comb begin
        q_neg = dvd_neg ^ dsr_neg;
        ovf   = q_neg ? (q_mag > LIM_NEG) : (q_mag > LIM_POS);
        quot  = q_neg ? (~q_mag[W-1:0] + 1'b1) : q_mag[W-1:0];
        rem   = dvd_neg ? (~r_mag + 1'b1) : r_mag;
        if (ovf) begin
            cc   = CC_CLEAR;
            cc.v = 1'b1;
        end else begin
            cc   = CC_CLEAR;
            cc.n = quot[W-1];
            cc.z = (quot == '0);
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         op,
    input  logic [W-1:0] pair_hi,
    input  logic [W-1:0] pair_lo,
    input  logic [W-1:0] src,
    output logic         busy,
    output logic         done,
    output logic         wr_en,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] ODD_DIVIDEND = {1'b1, {(DW-1){1'b0}}};
    localparam logic [W-1:0]  ODD_DIVISOR  = W'(1);

    md_state_t state_q, state_d;

    md_op_t        op_q;
    logic [W-1:0]  hi_q, lo_q, src_q;

    logic [W-1:0]  res_hi_q, res_lo_q;
    md_cc_t        cc_q;
    logic          wr_q;

    logic          div_zero, div_odd, div_early;
    logic          div_load, div_step, div_last;
    logic [DW-1:0] div_qmag;
    logic [W-1:0]  div_rmag;

    logic [W-1:0]  mul_hi, mul_lo;
    md_cc_t        mul_cc;

    logic [W-1:0]  fix_quot, fix_rem;
    logic          fix_ovf;
    md_cc_t        fix_cc;

    // Operand screening for the divide
    always_comb begin
        div_zero  = (src_q == '0);
        div_odd   = ({hi_q, lo_q} == ODD_DIVIDEND) && (src_q == ODD_DIVISOR);
        div_early = div_zero | div_odd;
        div_load  = (state_q == S_DIV_CHECK) && !div_early;
        div_step  = (state_q == S_DIV_RUN);
    end

    muldiv_mul_path #(.W(W)) u_mul (
        .mcand   (hi_q),
        .mplier  (src_q),
        .prod_hi (mul_hi),
        .prod_lo (mul_lo),
        .cc      (mul_cc)
    );

    muldiv_div_iter #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .step     (div_step),
        .dividend ({hi_q, lo_q}),
        .divisor  (src_q),
        .q_mag    (div_qmag),
        .r_mag    (div_rmag),
        .last     (div_last)
    );

    muldiv_div_fix #(.W(W)) u_fix (
        .q_mag   (div_qmag),
        .r_mag   (div_rmag),
        .dvd_neg (hi_q[W-1]),
        .dsr_neg (src_q[W-1]),
        .quot    (fix_quot),
        .rem     (fix_rem),
        .ovf     (fix_ovf),
        .cc      (fix_cc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (md_op_t'(op) == OP_DIV) ? S_DIV_CHECK : S_MUL;
                end
            end
            S_MUL:       state_d = S_DONE;
            S_DIV_CHECK: state_d = div_early ? S_DONE : S_DIV_RUN;
            S_DIV_RUN:   state_d = div_last ? S_DIV_FIX : S_DIV_RUN;
            S_DIV_FIX:   state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Operand capture: only an accepted start loads new operands
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_MUL;
            hi_q  <= '0;
            lo_q  <= '0;
            src_q <= '0;
        end else if (state_q == S_IDLE && start) begin
            op_q  <= md_op_t'(op);
            hi_q  <= pair_hi;
            lo_q  <= pair_lo;
            src_q <= src;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_hi_q <= '0;
            res_lo_q <= '0;
            cc_q     <= CC_CLEAR;
            wr_q     <= 1'b0;
        end else begin
            unique case (state_q)
                S_MUL: begin
                    res_hi_q <= mul_hi;
                    res_lo_q <= mul_lo;
                    cc_q     <= mul_cc;
                    wr_q     <= 1'b1;
                end
                S_DIV_CHECK: begin
                    if (div_early) begin
                        res_hi_q <= hi_q;
                        res_lo_q <= lo_q;
                        cc_q     <= div_zero ? CC_DIV_ZERO : CC_DIV_ODD;
                        wr_q     <= 1'b0;
                    end
                end
                S_DIV_FIX: begin
                    res_hi_q <= fix_ovf ? hi_q : fix_quot;
                    res_lo_q <= fix_ovf ? lo_q : fix_rem;
                    cc_q     <= fix_cc;
                    wr_q     <= ~fix_ovf;
                end
                S_IDLE, S_DIV_RUN, S_DONE: begin
                    wr_q <= wr_q;
                end
                default: begin
                    wr_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        wr_en  = done & wr_q;
        res_hi = res_hi_q;
        res_lo = res_lo_q;
        flag_n = done & cc_q.n;
        flag_z = done & cc_q.z;
        flag_v = done & cc_q.v;
        flag_c = done & cc_q.c;
    end

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         op,
    input logic [W-1:0] pair_hi,
    input logic [W-1:0] pair_lo,
    input logic [W-1:0] src,
    input logic         busy,
    input logic         done,
    input logic         wr_en,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_v,
    input logic         flag_c
);
    logic         seen_div;
    logic         seen_zero;
    logic [W-1:0] seen_hi, seen_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_div  <= 1'b0;
            seen_zero <= 1'b0;
            seen_hi   <= '0;
            seen_lo   <= '0;
        end else if (start && !busy) begin
            seen_div  <= op;
            seen_zero <= (src == '0);
            seen_hi   <= pair_hi;
            seen_lo   <= pair_lo;
        end
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst) start && !busy |=> busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done && !busy); // R10
    AST_WR_IN_DONE: assert property (@(posedge clk) disable iff (rst) wr_en |-> done); // R11
    AST_CC_IN_DONE: assert property (@(posedge clk) disable iff (rst) !done |-> !(flag_n || flag_z || flag_v || flag_c)); // R11
    AST_MUL_WRITE: assert property (@(posedge clk) disable iff (rst) done && !seen_div |-> wr_en && !flag_v); // R1
    AST_MUL_NZ: assert property (@(posedge clk) disable iff (rst) done && !seen_div |-> flag_n == res_hi[W-1] && flag_z == ({res_hi, res_lo} == '0)); // R2
    AST_MUL_RANGE: assert property (@(posedge clk) disable iff (rst) done && !seen_div |-> flag_c == (res_hi != {W{res_lo[W-1]}})); // R3
    AST_DIV_OK_FLAGS: assert property (@(posedge clk) disable iff (rst) wr_en && seen_div |-> !flag_v && !flag_c && flag_n == res_hi[W-1] && flag_z == (res_hi == '0)); // R5
    AST_DIV_NO_WRITE: assert property (@(posedge clk) disable iff (rst) done && seen_div && flag_v |-> !wr_en && res_hi == seen_hi && res_lo == seen_lo); // R6
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst) done && seen_div && seen_zero |-> !flag_n && flag_z && flag_v && flag_c); // R7

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .pair_hi (pair_hi),
    .pair_lo (pair_lo),
    .src     (src),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .res_hi  (res_hi),
    .res_lo  (res_lo),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .flag_c  (flag_c)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int DW         = 2 * W;
    localparam int LAT_SHORT  = 2;
    localparam int LAT_LONG   = DW + 3;
    localparam int WAIT_LIMIT = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          op = 1'b0;
    logic [W-1:0]  pair_hi = '0;
    logic [W-1:0]  pair_lo = '0;
    logic [W-1:0]  src = '0;
    logic          busy, done, wr_en;
    logic [W-1:0]  res_hi, res_lo;
    logic          flag_n, flag_z, flag_v, flag_c;

    int n_checks = 0;
    int n_errors = 0;

    muldiv_unit #(.W(W)) u_muldiv_unit (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op      (op),
        .pair_hi (pair_hi),
        .pair_lo (pair_lo),
        .src     (src),
        .busy    (busy),
        .done    (done),
        .wr_en   (wr_en),
        .res_hi  (res_hi),
        .res_lo  (res_lo),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .flag_v  (flag_v),
        .flag_c  (flag_c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements (flags packed {N,Z,V,C})
    task automatic ref_op(input logic rop, input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] s, output logic [W-1:0] eh, output logic [W-1:0] el,
                          output logic [3:0] ecc, output logic ewr, output int lat, output string rq);
        longint a, b, p, d, q, r;
        logic [63:0] pv, qv, rv;
        if (!rop) begin
            a = longint'($signed(hi));
            b = longint'($signed(s));
            p = a * b;
            pv = p;
            eh = pv[31:16];
            el = pv[15:0];
            ecc = {pv[31], p == 0, 1'b0, (p < -32768) || (p > 32767)};
            ewr = 1'b1;
            lat = LAT_SHORT;
            rq = "R1/R2/R3";
        end else begin
            d = longint'($signed({hi, lo}));
            b = longint'($signed(s));
            eh = hi;
            el = lo;
            ewr = 1'b0;
            if (b == 0) begin
                ecc = 4'b0111; lat = LAT_SHORT; rq = "R7";
            end else if (d == -64'sd2147483648 && b == 1) begin
                ecc = 4'b1110; lat = LAT_SHORT; rq = "R8";
            end else begin
                q = d / b;
                r = d % b;
                lat = LAT_LONG;
                if (q > 32767 || q < -32768) begin
                    ecc = 4'b0010; rq = "R6";
                end else begin
                    qv = q; rv = r;
                    eh = qv[15:0];
                    el = rv[15:0];
                    ecc = {qv[15], q == 0, 1'b0, 1'b0};
                    ewr = 1'b1;
                    rq = "R4/R5";
                end
            end
        end
    endtask

    // One operation; with poke set, start is raised again mid-divide with other operands
    task automatic run_op(input logic rop, input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] s, input bit poke);
        logic [W-1:0] eh, el;
        logic [3:0]   ecc;
        logic         ewr;
        int           lat, n;
        string        rq;
        ref_op(rop, hi, lo, s, eh, el, ecc, ewr, lat, rq);
        @(negedge clk);
        op = rop; pair_hi = hi; pair_lo = lo; src = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk("R10", "busy after accepted start", busy, 1);
        chk("R11", "wr_en/flags before done", {wr_en, flag_n, flag_z, flag_v, flag_c}, 0);
        while (!done && n < WAIT_LIMIT) begin
            if (poke && n == 3) begin
                start = 1'b1; op = ~rop; pair_hi = 16'h1234; pair_lo = 16'h5678; src = 16'h0003;
            end
            if (poke && n == 6) start = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk("R9", "done latency in edges", n, lat);
        chk(rq, "wr_en", wr_en, ewr);
        chk(rq, "res_hi", res_hi, eh);
        chk(rq, "res_lo", res_lo, el);
        chk(rq, "flags NZVC", {flag_n, flag_z, flag_v, flag_c}, ecc);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "done/busy one cycle after done", {done, busy}, 0);
        chk("R11", "wr_en/flags after done", {wr_en, flag_n, flag_z, flag_v, flag_c}, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "idle outputs in reset", {busy, done, wr_en, flag_n, flag_z, flag_v, flag_c}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "idle outputs after reset", {busy, done, wr_en, flag_n, flag_z, flag_v, flag_c}, 0);
    endtask

    task automatic t_mul_cases();
        run_op(1'b0, 16'd2,    16'hFFFF, 16'd3,    1'b0); // R1 pair_lo ignored
        run_op(1'b0, 16'h0000, 16'h0000, 16'h1234, 1'b0); // R2 zero product
        run_op(1'b0, 16'h8000, 16'h0000, 16'h8000, 1'b0); // R3 0x40000000
        run_op(1'b0, 16'h8000, 16'h0000, 16'h0001, 1'b0); // R3 -32768 fits
        run_op(1'b0, 16'h8000, 16'h0000, 16'hFFFF, 1'b0); // R3 +32768 out of range
        run_op(1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0); // R2 -1*-1
        run_op(1'b0, 16'h7FFF, 16'h0000, 16'h7FFF, 1'b0); // R3
        run_op(1'b0, 16'h0100, 16'h0000, 16'h0080, 1'b0); // R3 32768 boundary
        run_op(1'b0, 16'hFF00, 16'h0000, 16'h0080, 1'b0); // R3 -32768 boundary
    endtask

    task automatic t_div_signs();
        run_op(1'b1, 16'h0000, 16'd7,    16'd2,    1'b0); // R4 3 r 1
        run_op(1'b1, 16'hFFFF, 16'hFFF9, 16'd2,    1'b0); // R4 -7/2: -3 r -1
        run_op(1'b1, 16'h0000, 16'd7,    16'hFFFE, 1'b0); // R4 7/-2: -3 r 1
        run_op(1'b1, 16'hFFFF, 16'hFFF9, 16'hFFFE, 1'b0); // R4 -7/-2: 3 r -1
        run_op(1'b1, 16'h0000, 16'd0,    16'd5,    1'b0); // R5 zero quotient
        run_op(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0); // R5 -1/-1
    endtask

    task automatic t_div_overflow();
        run_op(1'b1, 16'h0000, 16'h7FFF, 16'h0001, 1'b0); // R5 largest positive
        run_op(1'b1, 16'h0000, 16'h8000, 16'h0001, 1'b0); // R6 32768
        run_op(1'b1, 16'hFFFF, 16'h8000, 16'h0001, 1'b0); // R5 -32768 fits
        run_op(1'b1, 16'hFFFF, 16'h8000, 16'hFFFF, 1'b0); // R6 +32768
        run_op(1'b1, 16'h8000, 16'h0000, 16'hFFFF, 1'b0); // R6 -2^31/-1
        run_op(1'b1, 16'h7FFF, 16'hFFFF, 16'h7FFF, 1'b0); // R6
        run_op(1'b1, 16'h4000, 16'h0000, 16'h8000, 1'b0); // R5 -32768 quotient
    endtask

    task automatic t_div_special();
        run_op(1'b1, 16'h0000, 16'd5,    16'h0000, 1'b0); // R7
        run_op(1'b1, 16'h8000, 16'h0000, 16'h0000, 1'b0); // R7 precedence over R8
        run_op(1'b1, 16'h8000, 16'h0000, 16'h0001, 1'b0); // R8
        run_op(1'b1, 16'h8000, 16'h0001, 16'h0001, 1'b0); // R6 neighbour of R8
    endtask

    task automatic t_busy_ignore();
        run_op(1'b1, 16'h0001, 16'h2345, 16'h0123, 1'b1); // R10 start ignored while busy
        run_op(1'b1, 16'h0000, 16'd5,    16'h0000, 1'b0); // R10 back-to-back
    endtask

    task automatic t_reset_midway();
        @(negedge clk);
        op = 1'b1; pair_hi = 16'h0001; pair_lo = 16'h0000; src = 16'h0007; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R12", "mid-op reset returns to idle", {busy, done, wr_en}, 0);
        rst = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R12", "no done after mid-op reset", {busy, done}, 0);
        run_op(1'b0, 16'h0003, 16'h0000, 16'hFFFB, 1'b0); // R12 usable after reset
    endtask

    task automatic t_random();
        logic [W-1:0] h, l, s;
        for (int i = 0; i < 160; i++) begin
            l = W'($urandom);
            s = W'($urandom);
            h = (i % 2 == 0) ? {W{l[W-1]}} : W'($urandom);
            if (i % 5 == 0) s = {{(W-4){s[W-1]}}, s[3:0]};
            run_op(i % 3 == 0 ? 1'b0 : 1'b1, h, l, s, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_mul_cases();
        t_div_signs();
        t_div_overflow();
        t_div_special();
        t_busy_ignore();
        t_reset_midway();
        t_random();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule